// File: doc/BRIEF.md
# Row Miss Statistics Tracker

This block sits inside a hybrid memory controller and watches the traffic that goes to the slow, non-volatile tier. Each access arrives with its row address and a flag that says whether the bank's open row already held that row. The block keeps a small set-associative table of recently touched rows. Each entry holds a saturating count of row-buffer misses. A row that keeps missing in the slow tier's row buffer is a good candidate to move into the fast tier. When such a row's count passes a programmable threshold, the block raises a one-cycle migration request that carries the row address.

Lookup, allocation and update all complete in one cycle per accepted access. A free-running interval timer wipes every counter at once. This keeps rows that are touched only now and then from slowly building up enough misses to trigger. The table geometry, the counter width and the interval length are parameters.

Top module: `rowMissTracker`

## Requirements
- R1: An access is accepted on a clock edge where accValid and accReady are both high. The set index is the low log2(SETS) bits of accRow and the tag is the remaining upper bits. While accValid is low the table does not change.
- R2: When an accepted access finds no valid entry with a matching tag, it allocates a way in its set: an invalid way if one exists, otherwise the least recently used way. The new counter is 1 if the access was a row-buffer miss (accIsMiss=1) and 0 otherwise.
- R3: When an accepted access matches an entry, the counter increments by one if accIsMiss=1 and stays unchanged if accIsMiss=0.
- R4: Counters saturate at 2^CNT_W-1 and never wrap to a smaller value.
- R5: Every accepted access, whether hit or miss, makes its entry the most recently used way of its set. Eviction always picks the way touched longest ago.
- R6: On every accepted access, the resulting counter value is compared with missThresh, even when the value did not change. If it is strictly greater, migValid is high for exactly the cycle after the accepting edge and migRow equals the accessed row. Otherwise migValid stays low.
- R7: The entry that raised a migration request is invalidated, so the next access to that row allocates a fresh entry.
- R8: Every INTERVAL cycles, counting from reset, all counters are cleared in a single cycle. Tags, valid bits and recency order are kept. accReady is low in that cycle only, so an access offered then waits for the next cycle.
- R9: After reset every entry is invalid, migValid is low and accReady is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | Access offered |
| accReady | output | 1 | Block can accept an access this cycle |
| accRow | input | ROW_W | Row address of the slow-tier access |
| accIsMiss | input | 1 | 1 when the access missed in the bank's row buffer |
| missThresh | input | CNT_W | A migration fires when a count exceeds this value |
| migValid | output | 1 | One-cycle migration request |
| migRow | output | ROW_W | Row to migrate, valid with migValid |

## Verification
The bench aims at the strict comparison. A design that fires at equality would request a row one miss too early. It checks that row-buffer hits leave the count alone, so a design that counts plain accesses would fire on a row with good locality. Saturation is exposed by lowering the threshold below the maximum after many misses and then sending a single hit. A wrapping counter would stay silent there. Further cases cover:
- eviction order, where a design that evicts the wrong way loses a nearly-triggered row or keeps a stale one;
- re-allocation after a migration, where a design that keeps the entry counts on from the old value;
- the interval clear, where a missing clear fires on the very first miss after the wipe.

// File: rtl/rmtPkg.sv
package rmtPkg;
  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic access;   // apply the current access to the table
    logic clear;    // wipe every miss counter
  } rmtStrobes_t;
endpackage

// File: rtl/rmtCtrl.sv
module rmtCtrl #(
  parameter int INTERVAL = 10_000_000,
  parameter int ROW_W    = 20
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               accValid,
  input  logic [ROW_W-1:0]   accRow,
  input  logic               trigger,
  output logic               accReady,
  output rmtPkg::rmtStrobes_t strb,
  output logic               migValid,
  output logic [ROW_W-1:0]   migRow
);
  localparam int TMR_W = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(INTERVAL - 1);

  logic [TMR_W-1:0] timer;
  logic             clearNow;

  assign clearNow    = (timer == TMR_LAST);
  assign accReady    = !clearNow;
  assign strb.clear  = clearNow;
  assign strb.access = accValid && !clearNow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timer    <= '0;
      migValid <= 1'b0;
      migRow   <= '0;
    end else begin
      timer    <= clearNow ? '0 : timer + 1'b1;
      migValid <= strb.access && trigger;
      if (strb.access && trigger) migRow <= accRow;
    end
  end

  // R6: a request only ever follows an accepted access
  a_r6_mig_after_access: assert property (@(posedge clk) disable iff (!rstN)
    migValid |-> $past(strb.access));

  // R8: the clear occupies a single cycle
  a_r8_clear_single: assert property (@(posedge clk) disable iff (!rstN)
    clearNow |=> !clearNow);

  // R8: no access is taken while the wipe is in progress
  a_r8_no_accept_on_clear: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |-> !accReady);
endmodule

// File: rtl/rmtDatapath.sv
module rmtDatapath #(
  parameter int WAYS  = 16,
  parameter int SETS  = 128,
  parameter int CNT_W = 5,
  parameter int ROW_W = 20
) (
  input  logic               clk,
  input  logic               rstN,
  input  rmtPkg::rmtStrobes_t strb,
  input  logic [ROW_W-1:0]   accRow,
  input  logic               accIsMiss,
  input  logic [CNT_W-1:0]   missThresh,
  output logic               trigger
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ROW_W - IDX_W;
  localparam int WAY_W = $clog2(WAYS);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [WAY_W-1:0] AGE_OLDEST = WAY_W'(WAYS - 1);

  logic [TAG_W-1:0] tagMem   [SETS][WAYS];
  logic [CNT_W-1:0] cntMem   [SETS][WAYS];
  logic             validMem [SETS][WAYS];
  logic [WAY_W-1:0] ageMem   [SETS][WAYS];

  logic [IDX_W-1:0] setIdx;
  logic [TAG_W-1:0] tagIn;
  logic [WAYS-1:0]  hitVec;
  logic             hit, invFound;
  logic [WAY_W-1:0] hitWay, invWay, lruWay, selWay, selAge;
  logic [CNT_W-1:0] curCnt, nextCnt;

  assign setIdx = accRow[IDX_W-1:0];
  assign tagIn  = accRow[ROW_W-1:IDX_W];

  // tag compare, one comparator per way
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hitVec[w] = validMem[setIdx][w] && (tagMem[setIdx][w] == tagIn);
  end

  // way selection
  always_comb begin
    hit      = |hitVec;
    hitWay   = '0;
    invFound = 1'b0;
    invWay   = '0;
    lruWay   = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hitVec[w]) hitWay = WAY_W'(w);
      if (!validMem[setIdx][w]) begin
        invFound = 1'b1;
        invWay   = WAY_W'(w);
      end
      if (ageMem[setIdx][w] == AGE_OLDEST) lruWay = WAY_W'(w);
    end
    if (hit)           selWay = hitWay;
    else if (invFound) selWay = invWay;
    else               selWay = lruWay;
    selAge = ageMem[setIdx][selWay];
  end

  // counter update and threshold compare
  always_comb begin
    curCnt = hit ? cntMem[setIdx][hitWay] : '0;
    if (!hit)                               nextCnt = {{(CNT_W-1){1'b0}}, accIsMiss};
    else if (accIsMiss && curCnt != CNT_MAX) nextCnt = curCnt + 1'b1;
    else                                     nextCnt = curCnt;
    trigger = (nextCnt > missThresh);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          tagMem[s][w]   <= '0;
          cntMem[s][w]   <= '0;
          validMem[s][w] <= 1'b0;
          ageMem[s][w]   <= WAY_W'(w);
        end
      end
    end else if (strb.clear) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) cntMem[s][w] <= '0;
      end
    end else if (strb.access) begin
      tagMem[setIdx][selWay]   <= tagIn;
      cntMem[setIdx][selWay]   <= nextCnt;
      validMem[setIdx][selWay] <= !trigger;
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == selWay)         ageMem[setIdx][w] <= '0;
        else if (ageMem[setIdx][w] < selAge) ageMem[setIdx][w] <= ageMem[setIdx][w] + 1'b1;
      end
    end
  end

  // ---- checks ----
  logic anyCnt;
  always_comb begin
    anyCnt = 1'b0;
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++)
        anyCnt = anyCnt | (|cntMem[s][w]);
  end

  // R1: a row lives in at most one way of its set
  a_r1_single_match: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec));

  // R4: a matched entry never moves to a smaller count
  always_comb begin
    if (rstN && hit) a_r4_no_wrap: assert (nextCnt >= curCnt);
  end

  // R8: after a wipe no counter holds a value
  a_r8_all_cleared: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> !anyCnt);

  // R7: a triggering entry is dropped from the table
  a_r7_invalidate: assert property (@(posedge clk) disable iff (!rstN)
    (strb.access && trigger) |=> !validMem[$past(setIdx)][$past(selWay)]);
endmodule

// File: rtl/rowMissTracker.sv
module rowMissTracker #(
  parameter int WAYS     = 16,
  parameter int SETS     = 128,
  parameter int CNT_W    = 5,
  parameter int ROW_W    = 20,
  parameter int INTERVAL = 10_000_000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             accValid,
  output logic             accReady,
  input  logic [ROW_W-1:0] accRow,
  input  logic             accIsMiss,
  input  logic [CNT_W-1:0] missThresh,
  output logic             migValid,
  output logic [ROW_W-1:0] migRow
);
  rmtPkg::rmtStrobes_t strb;
  logic trigger;

  rmtCtrl #(.INTERVAL(INTERVAL), .ROW_W(ROW_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accRow(accRow),
    .trigger(trigger), .accReady(accReady), .strb(strb),
    .migValid(migValid), .migRow(migRow));

  rmtDatapath #(.WAYS(WAYS), .SETS(SETS), .CNT_W(CNT_W), .ROW_W(ROW_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .accRow(accRow),
    .accIsMiss(accIsMiss), .missThresh(missThresh), .trigger(trigger));
endmodule

// File: tb/rowMissTracker_tb.sv
`timescale 1ns/1ps
module rowMissTracker_tb_top;
  localparam int ROW_W = 8;
  localparam int CNT_W = 3;
  localparam int INTERVAL = 300;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic accValid = 1'b0;
  logic accReady;
  logic [ROW_W-1:0] accRow = '0;
  logic accIsMiss = 1'b0;
  logic [CNT_W-1:0] missThresh = '0;
  logic migValid;
  logic [ROW_W-1:0] migRow;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rowMissTracker #(.WAYS(4), .SETS(4), .CNT_W(CNT_W), .ROW_W(ROW_W), .INTERVAL(INTERVAL)) dut_i (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accReady(accReady),
    .accRow(accRow), .accIsMiss(accIsMiss), .missThresh(missThresh),
    .migValid(migValid), .migRow(migRow));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one access; returns migValid/migRow seen the cycle after acceptance
  task automatic acc(input logic [ROW_W-1:0] r, input bit m, output bit f, output logic [ROW_W-1:0] fr);
    @(negedge clk);
    accValid = 1'b1; accRow = r; accIsMiss = m;
    while (!accReady) @(negedge clk);
    @(negedge clk);
    f = migValid; fr = migRow;
    accValid = 1'b0;
  endtask

  task automatic waitClear();
    @(negedge clk);
    while (accReady) @(negedge clk);
  endtask

  task automatic tReset();
    chk("R9 migValid after reset", migValid, 0);
    chk("R9 accReady after reset", accReady, 1);
  endtask

  task automatic tStrict();
    bit f; logic [ROW_W-1:0] fr;
    waitClear(); missThresh = 3'd2;
    acc(8'h10, 1, f, fr); chk("R2 alloc miss count 1 no fire", f, 0);
    acc(8'h10, 1, f, fr); chk("R6 count equals threshold no fire", f, 0);
    acc(8'h10, 1, f, fr); chk("R6 count above threshold fires", f, 1);
    chk("R6 migRow", fr, 8'h10);
    // R7: entry dropped, next access reallocates at 1
    acc(8'h10, 1, f, fr); chk("R7 realloc count 1", f, 0);
    acc(8'h10, 1, f, fr); chk("R7 realloc count 2", f, 0);
    acc(8'h10, 1, f, fr); chk("R7 realloc fires at 3", f, 1);
  endtask

  task automatic tHits();
    bit f; logic [ROW_W-1:0] fr;
    waitClear(); missThresh = 3'd1;
    acc(8'h21, 1, f, fr);
    for (int i = 0; i < 3; i++) begin
      acc(8'h21, 0, f, fr); chk("R3 hit leaves count", f, 0);
    end
    acc(8'h21, 1, f, fr); chk("R3 miss increments and fires", f, 1);
    chk("R6 migRow hits test", fr, 8'h21);
  endtask

  task automatic tIdle();
    bit f; logic [ROW_W-1:0] fr;
    waitClear(); missThresh = 3'd1;
    acc(8'h50, 1, f, fr);
    @(negedge clk); accRow = 8'h50; accIsMiss = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 no request while idle", migValid, 0);
    acc(8'h50, 0, f, fr); chk("R1 idle cycles did not count", f, 0);
    acc(8'h50, 1, f, fr); chk("R1 count resumes", f, 1);
  endtask

  task automatic tAllocHit();
    bit f; logic [ROW_W-1:0] fr;
    waitClear(); missThresh = 3'd0;
    acc(8'h33, 0, f, fr); chk("R2 alloc on hit starts at 0", f, 0);
    acc(8'h33, 1, f, fr); chk("R3 first miss fires at thresh 0", f, 1);
    acc(8'h37, 1, f, fr); chk("R2 alloc on miss fires at thresh 0", f, 1);
    chk("R6 migRow alloc", fr, 8'h37);
  endtask

  task automatic tLru();
    bit f; logic [ROW_W-1:0] fr;
    waitClear(); missThresh = 3'd5;
    for (int i = 0; i < 5; i++) acc(8'h02, 1, f, fr);
    for (int i = 0; i < 5; i++) acc(8'h06, 1, f, fr);
    chk("R6 count 5 at thresh 5 no fire", f, 0);
    acc(8'h0A, 1, f, fr);
    acc(8'h0E, 1, f, fr);
    acc(8'h02, 0, f, fr); chk("R5 hit refreshes recency no fire", f, 0);
    acc(8'h12, 1, f, fr);  // evicts 0x06
    acc(8'h06, 1, f, fr); chk("R5 LRU way was evicted", f, 0);
    acc(8'h02, 1, f, fr); chk("R5 MRU way survived", f, 1);
    chk("R5 migRow survivor", fr, 8'h02);
  endtask

  task automatic tSat();
    bit f; logic [ROW_W-1:0] fr;
    waitClear(); missThresh = 3'd7;
    for (int i = 0; i < 12; i++) acc(8'h45, 1, f, fr);
    chk("R4 max threshold never fires", f, 0);
    missThresh = 3'd6;
    acc(8'h45, 0, f, fr); chk("R4 saturated count fires on hit", f, 1);
  endtask

  task automatic tClear();
    bit f; logic [ROW_W-1:0] fr;
    int gap;
    waitClear(); missThresh = 3'd3;
    for (int i = 0; i < 3; i++) acc(8'h3B, 1, f, fr);
    waitClear();
    gap = 0;
    @(negedge clk);
    while (accReady) begin gap++; @(negedge clk); end
    chk("R8 clear period", gap + 1, INTERVAL);
    acc(8'h3B, 1, f, fr); chk("R8 counters wiped", f, 0);
    acc(8'h3B, 1, f, fr);
    acc(8'h3B, 1, f, fr); chk("R8 count 3 after wipe no fire", f, 0);
    acc(8'h3B, 1, f, fr); chk("R8 entry kept through wipe fires", f, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tStrict();
    tHits();
    tIdle();
    tAllocHit();
    tLru();
    tSat();
    tClear();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule